// File: doc/BRIEF.md
# I2C Target with Register RAM Access

This block is an I2C target that lets an external bus controller read and write a byte-wide internal RAM through a 16-bit register pointer. The pointer is held inside the block and keeps its value from one bus transaction to the next. A controller can therefore aim the pointer in one transfer and read from that spot in a later, separate transfer. It can also combine both steps in one transfer, using a repeated start between the write phase and the read phase.

SCL and SDA are sampled on a fast system clock. Each line passes through a two-flop synchronizer and then a spike filter, and only after that are edges and bus conditions detected. The block pulls SDA low through an open-drain enable output. It never drives the line high. The pointer is 16 bits wide, and the RAM is indexed by its low `RAM_AW` bits.

In a write transfer, the first two data bytes set the pointer and any bytes after them go to RAM. A read transfer returns RAM bytes starting at the current pointer. After each byte stored or returned, the pointer moves on by one.

Top module: `i2c_regram_target`

## Requirements
- R1: The address byte is {7-bit address, direction bit}, where direction 1 means read. The block ACKs only when the upper seven bits equal `DEV_ADDR` (default 7'h2C). For any other address it leaves SDA released for the rest of that transfer. After reset, SDA is released.
- R2: In a write transfer, the first data byte becomes the pointer's high byte and the second becomes its low byte. Both bytes are ACKed.
- R3: Each later data byte of a write transfer is ACKed and stored at the RAM cell the pointer selects. The pointer then moves on by one.
- R4: A write transfer that carries only the two pointer bytes and then a stop changes no RAM cell. A later, separate read transfer starts at the pointer it set.
- R5: A read transfer returns bytes MSB first, starting at the current pointer. The pointer is not changed before the first byte, and it moves on by one for each byte returned.
- R6: A pointer set followed by a repeated start and a read address returns data from the newly set pointer.
- R7: When the controller NACKs a read byte (SDA high in the ninth clock), the block stops returning data and keeps SDA released until the next start. A stop always releases SDA.
- R8: The pointer wraps from 16'hFFFF to 16'h0000. The RAM cell used is the low `RAM_AW` bits of the pointer (default 8).
- R9: A start (SDA falling while SCL is high) or a stop (SDA rising while SCL is high) that arrives in the middle of a byte discards that partial byte. No RAM cell and no pointer byte is changed by it.
- R10: A new level on SCL or SDA is taken only after it has held for `STABLE_CLKS` system clocks (default 3). A pulse of `STABLE_CLKS-1` clocks or less has no effect.
- R11: The block changes its SDA drive only while the filtered SCL is low. The MSB of each read byte is on SDA before the SCL rise that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_drive_low | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The assertions assume that the controller moves SDA only while SCL is low, except when it makes a start or a stop. They also assume that it raises a start or a stop only while the target has SDA released. Every SCL high and low phase is assumed to last much longer than the synchronizer plus the filter delay.

The stimulus keeps to these limits in every transfer. It changes data a quarter period after the SCL fall, and it holds each SCL phase for 24 system clocks. The only deliberate breaks are the filter tests, whose pulses are kept below the filter length. The other break is the abort case, where a start or a stop lands in the middle of a byte while the target is not driving SDA.

// File: rtl/i2c_regram_pkg.sv
package i2c_regram_pkg;

  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BITS,
    ST_WR_ACK,
    ST_RD_BITS,
    ST_RD_ACK,
    ST_RD_WAIT
  } tgt_state_t;

  // next pointer value, wrapping at the top of the 16-bit space
  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction

  // the address frame targets this device when its upper seven bits match
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int   STABLE_CLKS = 3,
  parameter logic RST_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(STABLE_CLKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          clean_q;
  logic          differs;

  assign differs = sync_q[1] != clean_q;
  assign clean   = clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {2{RST_LVL}};
      cnt_q   <= '0;
      clean_q <= RST_LVL;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (differs) begin
        if (cnt_q == CW'(STABLE_CLKS - 1)) begin
          clean_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R10: the filtered level only moves to a value the synchronized input already holds
  assert_filter_settled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q != $past(clean_q)) |-> ($past(sync_q[1]) == clean_q));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2c_regram_mem.sv
module i2c_regram_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regram_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [7:0]       rd_byte,
  output logic             drive_low,
  output logic [PTR_W-1:0] ptr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata
);
  tgt_state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [1:0] widx;
  logic       rw;

  // named internal events
  logic quiet_edge;
  logic bit_in;
  logic byte_done;
  logic rd_load;
  logic ptr_step;

  assign quiet_edge = ~start_ev & ~stop_ev;
  assign bit_in     = quiet_edge & scl_rise & (cnt < 4'd8);
  assign byte_done  = quiet_edge & scl_fall & (cnt == 4'd8);
  assign mem_we     = byte_done & (state == ST_WR_BITS) & (widx == 2'd2);
  assign mem_wdata  = shreg;
  assign rd_load    = quiet_edge & scl_fall &
                      (((state == ST_ADDR_ACK) & rw) | (state == ST_RD_WAIT));
  assign ptr_step   = mem_we | rd_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      widx      <= '0;
      rw        <= 1'b0;
      ptr       <= '0;
      drive_low <= 1'b0;
    end else if (start_ev) begin
      state     <= ST_ADDR;
      cnt       <= '0;
      widx      <= '0;
      drive_low <= 1'b0;
    end else if (stop_ev) begin
      state     <= ST_IDLE;
      drive_low <= 1'b0;
    end else begin
      if (rd_load) begin
        shreg     <= rd_byte;
        drive_low <= ~rd_byte[7];
        cnt       <= 4'd1;
        ptr       <= ptr_advance(ptr);
        state     <= ST_RD_BITS;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (bit_in) begin
              shreg <= {shreg[6:0], sda};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              if (addr_hit(shreg, DEV_ADDR)) begin
                drive_low <= 1'b1;
                rw        <= shreg[0];
                state     <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              drive_low <= 1'b0;
              cnt       <= '0;
              state     <= ST_WR_BITS;
            end
          end
          ST_WR_BITS: begin
            if (bit_in) begin
              shreg <= {shreg[6:0], sda};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              drive_low <= 1'b1;
              state     <= ST_WR_ACK;
              unique case (widx)
                2'd0: begin ptr[PTR_W-1:8] <= shreg; widx <= 2'd1; end
                2'd1: begin ptr[7:0] <= shreg; widx <= 2'd2; end
                default: ptr <= ptr_advance(ptr);
              endcase
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              drive_low <= 1'b0;
              cnt       <= '0;
              state     <= ST_WR_BITS;
            end
          end
          ST_RD_BITS: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                drive_low <= 1'b0;
                state     <= ST_RD_ACK;
              end else begin
                drive_low <= ~shreg[6];
                shreg     <= {shreg[6:0], 1'b0};
                cnt       <= cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) state <= sda ? ST_IDLE : ST_RD_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a foreign address leaves SDA released after the address byte
  assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_done && !addr_hit(shreg, DEV_ADDR)) |=> !drive_low);

  // R3: every data byte stored or returned moves the pointer by exactly one
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (ptr == ptr_advance($past(ptr))));

  // R7: a stop always leaves SDA released
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !drive_low);

  // R9: a start restarts framing at the address byte, whatever was in flight
  assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR && cnt == 4'd0));

  // R11: the drive only changes while the filtered SCL is low
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low != $past(drive_low)) |-> !scl);

endmodule

// File: rtl/i2c_regram_target.sv
module i2c_regram_target
  import i2c_regram_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         STABLE_CLKS = 3,
  parameter int         RAM_AW      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_drive_low
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] clean_lines;
  logic             scl_f, sda_f;
  logic             scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]       rd_byte, mem_wdata;
  logic             mem_we;
  logic [PTR_W-1:0] ptr;

  assign raw_lines = {sda_in, scl_in};
  assign scl_f     = clean_lines[0];
  assign sda_f     = clean_lines[1];

  for (genvar i = 0; i < LINES; i++) begin : g_filt
    i2c_glitch_filter #(
      .STABLE_CLKS(STABLE_CLKS),
      .RST_LVL    (1'b1)
    ) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[i]),
      .clean(clean_lines[i])
    );
  end

  i2c_bus_events events_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_f),
    .sda     (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_target_fsm #(
    .DEV_ADDR(DEV_ADDR)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_byte  (rd_byte),
    .drive_low(sda_drive_low),
    .ptr      (ptr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata)
  );

  i2c_regram_mem #(
    .AW(RAM_AW)
  ) mem_i (
    .clk  (clk),
    .we   (mem_we),
    .waddr(ptr[RAM_AW-1:0]),
    .wdata(mem_wdata),
    .raddr(ptr[RAM_AW-1:0]),
    .rdata(rd_byte)
  );

  // R1: nothing is driven onto SDA during the reset-release cycle
  assert_reset_released_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !sda_drive_low);

endmodule

// File: tb/i2c_regram_target_tb_top.sv
module i2c_regram_target_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 24;
  localparam logic [6:0] DEV        = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drv;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit quiet  = 1'b1;
  bit done   = 1'b0;

  logic [7:0] mem_ref [int];
  int         ptr_ref = 0;
  logic [7:0] wq [$];

  assign sda_line = sda_m & ~sda_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regram_target dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_m),
    .sda_in       (sda_line),
    .sda_drive_low(sda_drv)
  );

  // per-clock comparison: outside its own transfers the target must stay off the bus (R1)
  always @(negedge clk) begin
    if (rst_n && quiet && !done) begin
      checks++;
      if (sda_drv) begin
        errors++;
        $display("FAIL R1: SDA driven while target should be released, actual=1 expected=0");
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; clks(HALF/2);
    scl_m = 1'b1; clks(HALF);
    sda_m = 1'b0; clks(HALF);
    scl_m = 1'b0; clks(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; clks(HALF/2);
    scl_m = 1'b1; clks(HALF);
    sda_m = 1'b1; clks(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    clks(HALF/2);
    scl_m = 1'b1; clks(HALF);
    scl_m = 1'b0; clks(HALF/2);
  endtask

  // mode 1: short SDA spike in the high phase; mode 2: short SCL dip in the high phase
  task automatic send_bit_spiky(input logic b, input int mode);
    sda_m = b;    clks(HALF/2);
    scl_m = 1'b1; clks(6);
    if (mode == 1) begin sda_m = ~b; clks(2); sda_m = b; end
    else begin scl_m = 1'b0; clks(2); scl_m = 1'b1; end
    clks(HALF-8);
    scl_m = 1'b0; clks(HALF/2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; clks(HALF/2);
    scl_m = 1'b1; clks(HALF/2);
    acked = (sda_line == 1'b0);
    clks(HALF/2);
    scl_m = 1'b0; clks(HALF/2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clks(HALF/2);
      scl_m = 1'b1; clks(HALF/2);
      d = {d[6:0], sda_line};
      clks(HALF/2);
      scl_m = 1'b0;
    end
    clks(HALF/2);
    sda_m = nack; clks(HALF/2);
    scl_m = 1'b1; clks(HALF);
    scl_m = 1'b0; clks(HALF/2);
    sda_m = 1'b1;
  endtask

  // start + address (write) + two pointer bytes, leaving the bus mid-low
  task automatic set_ptr_phase(input int p);
    bit a;
    quiet = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a); check("R1 own address ack", a, 1);
    send_byte(p[15:8], a);     check("R2 pointer high ack", a, 1);
    send_byte(p[7:0], a);      check("R2 pointer low ack", a, 1);
    ptr_ref = p & 16'hFFFF;
  endtask

  task automatic wr_txn(input int p);
    bit a;
    set_ptr_phase(p);
    foreach (wq[i]) begin
      send_byte(wq[i], a); check("R3 data ack", a, 1);
      mem_ref[ptr_ref & 255] = wq[i];
      ptr_ref = (ptr_ref + 1) & 16'hFFFF;
    end
    bus_stop();
    quiet = 1'b1;
  endtask

  // start (or repeated start) + read address + n bytes, NACK on the last, then stop
  task automatic rd_body(input int n, input string req);
    bit a;
    logic [7:0] d;
    quiet = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, a); check("R1 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n-1, d);
      check({req, " R11 read byte"}, d, mem_ref[ptr_ref & 255]);
      ptr_ref = (ptr_ref + 1) & 16'hFFFF;
    end
    clks(4);
    check("R7 released after NACK", sda_drv, 0);
    bus_stop();
    check("R7 released after stop", sda_drv, 0);
    quiet = 1'b1;
  endtask

  initial begin
    bit a;
    clks(5);
    check("R1 reset released", sda_drv, 0);
    rst_n = 1'b1;
    clks(10);
    check("R1 after reset released", sda_drv, 0);

    // R1: foreign address is ignored (quiet stays set for the per-clock check)
    bus_start();
    send_byte({7'h2D, 1'b0}, a); check("R1 foreign address nack", a, 0);
    send_byte(8'h55, a);         check("R1 foreign data nack", a, 0);
    bus_stop();

    // R2 R3: pointer load then stored data
    wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_txn(16'h0010);

    // R4: pointer-only transfer, then separate read
    wq.delete();
    wr_txn(16'h0011);
    rd_body(2, "R4");
    // R5: next read continues from the advanced pointer
    rd_body(1, "R5");

    // R6: combined pointer set + repeated start + read
    set_ptr_phase(16'h0010);
    rd_body(4, "R6");

    // R8: wrap at the top of the pointer space
    wq = '{8'h5A, 8'h6B};
    wr_txn(16'hFFFF);
    check("R8 model pointer wrapped", ptr_ref, 16'h0001);
    set_ptr_phase(16'hFFFF);
    rd_body(2, "R8");
    rd_body(1, "R8 continue");

    // R10: spikes on SDA and SCL inside data bits are rejected
    quiet = 1'b0;
    set_ptr_phase(16'h0040);
    for (int i = 7; i >= 0; i--) begin
      if (i == 5) send_bit_spiky(1'b0, 1);
      else if (i == 2) send_bit_spiky(1'b1, 2);
      else send_bit(8'h96 >> i);
    end
    sda_m = 1'b1; clks(HALF/2);
    scl_m = 1'b1; clks(HALF/2);
    a = (sda_line == 1'b0);
    clks(HALF/2);
    scl_m = 1'b0; clks(HALF/2);
    check("R10 spiky byte ack", a, 1);
    mem_ref[8'h40] = 8'h96;
    ptr_ref = 16'h0041;
    bus_stop();
    quiet = 1'b1;
    set_ptr_phase(16'h0040);
    rd_body(1, "R10");

    // R9: stop in the middle of a data byte discards it
    wq = '{8'h11};
    wr_txn(16'h0050);
    set_ptr_phase(16'h0050);
    for (int i = 7; i >= 4; i--) send_bit(8'hEE >> i);
    bus_stop();
    quiet = 1'b1;
    rd_body(1, "R9 stop abort");
    // R9: repeated start in the middle of a data byte discards it
    set_ptr_phase(16'h0050);
    for (int i = 7; i >= 5; i--) send_bit(8'hEE >> i);
    rd_body(1, "R9 start abort");

    clks(20);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule